// File: doc/BRIEF.md
# Undefined-Length Burst Splitter

This block sits beside one master port of an AHB-style bus matrix and watches the incrementing bursts of undefined length (INCR) that the master issues. For each beat of such a burst it decides whether the arbiter may take the bus away after that beat. It flags such a beat with a predicted end-of-burst signal. It also gives a strobe once the flagged beat is accepted, so that the arbiter knows it may re-arbitrate.

A 3-bit policy code selects the behaviour. Code 0 leaves bursts whole. Code 1 turns every beat into a break point. Codes 2 to 7 cut the burst into pieces of 2^code beats. Two forced breaks apply under every code and win over the policy: the slave's slot-cycle limit, and the beat after which the address would cross a 1 KB boundary. The policy code lives in a small register. A write-protect input blocks writes to it, and the register can always be read back.

Top module: `incr_burst_splitter`

## Requirements
- R1: After reset the policy code reads back as 0, and no beat is flagged as an end of burst.
- R2: Under policy 0, an INCR beat is flagged only when the slot limit input is high or the beat reaches a 1 KB boundary.
- R3: Under every policy, an INCR beat is flagged when its address plus 2^size bytes carries out of the low 10 address bits (the next beat would start at a 1 KB multiple).
- R4: Under every policy, an INCR beat presented while the slot-limit input is high is flagged.
- R5: Under policy 1, every INCR beat (NONSEQ or SEQ) is flagged.
- R6: Under policy c in 2..7, the beat whose index within the current chunk is 2^c − 1 is flagged. Index 0 is the NONSEQ beat or the first beat after a break.
- R7: The chunk index restarts at 0 after every accepted flagged beat, whatever the cause of the break, and on every NONSEQ beat. It advances only when a SEQ beat is accepted with ready high. BUSY transfers and wait states (ready low) leave it unchanged.
- R8: No flag is raised for IDLE or BUSY transfers, or for bursts whose burst type is not INCR. Transfer type encoding: IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. INCR is burst code 001.
- R9: A write to the policy register takes effect when the write-protect input is low and is ignored when it is high. The read-back port always shows the stored code.
- R10: The re-arbitration strobe is high exactly when a flagged beat is presented with ready high. A flagged beat held in wait states raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| htrans_i | input | 2 | Master transfer type |
| hburst_i | input | 3 | Master burst type |
| hsize_i | input | 3 | Transfer size, log2 of bytes per beat |
| haddr_lo_i | input | 10 | Low address bits of the current beat |
| hready_i | input | 1 | Beat accepted this cycle |
| slot_limit_i | input | 1 | Slave arbiter reports its slot cycle limit reached |
| cfg_wr_i | input | 1 | Write strobe for the policy register |
| cfg_wdata_i | input | 3 | Policy code to write |
| cfg_wprot_i | input | 1 | Write protection, high blocks writes |
| cfg_rdata_o | output | 3 | Stored policy code |
| eob_o | output | 1 | Current beat is a predicted end of burst |
| rearb_o | output | 1 | Re-arbitration allowed, flagged beat accepted |

## Verification
The assertions assume that the master keeps the burst type constant across a burst. They also assume that a SEQ beat only ever follows a NONSEQ beat of the same burst, and that the policy code is not rewritten while an INCR burst is in flight. The directed stimulus keeps to these rules. Every burst opens with NONSEQ and its type is held until the next NONSEQ. Policy writes are made only while the bus is IDLE. Wait states and BUSY cycles are placed inside bursts, never before the opening beat.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
    localparam int POL_W      = 3;
    localparam int MAX_LOG2   = 7;
    localparam int CNT_W      = MAX_LOG2 + 1;
    localparam int BOUND_LOG2 = 10;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] BURST_INCR = 3'b001;

    localparam logic [POL_W-1:0] POL_WHOLE  = 3'd0;
    localparam logic [POL_W-1:0] POL_SINGLE = 3'd1;

    typedef logic [POL_W-1:0] policy_t;
endpackage

// File: rtl/splitter_cfg_reg.sv
module splitter_cfg_reg
    import splitter_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_i,
    input  policy_t wdata_i,
    input  logic    wprot_i,
    output policy_t policy_o
);
    typedef struct packed {
        policy_t pol;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i && !wprot_i) begin
            state_d.pol = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{pol: POL_WHOLE};
        end else begin
            state_q <= state_d;
        end
    end

    assign policy_o = state_q.pol;

    assert_protected_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wprot_i) |=> $stable(policy_o));
    assert_open_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wprot_i) |=> (policy_o == $past(wdata_i)));
endmodule

// File: rtl/splitter_bound.sv
module splitter_bound #(
    parameter int BOUND_LOG2 = 10
) (
    input  logic [BOUND_LOG2-1:0] addr_i,
    input  logic [2:0]            size_i,
    output logic                  cross_o
);
    localparam int SW = BOUND_LOG2 + 1;

    logic [SW-1:0] step_w;
    logic [SW-1:0] next_w;

    always_comb begin
        step_w  = SW'(1) << size_i;
        next_w  = {1'b0, addr_i} + step_w;
        cross_o = next_w[BOUND_LOG2];
    end
endmodule

// File: rtl/splitter_chunk_ctr.sv
module splitter_chunk_ctr
    import splitter_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  policy_t       policy_i,
    input  logic          beat_i,
    input  logic          first_i,
    input  logic          accept_i,
    input  logic          split_i,
    output logic          chunk_end_o
);
    typedef struct packed {
        logic [CW-1:0] idx;
    } ctr_state_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    ctr_state_t    state_d, state_q;
    logic [CW-1:0] cur_idx;
    logic [CW-1:0] last_idx;

    always_comb begin
        cur_idx  = first_i ? '0 : state_q.idx;
        if (policy_i == POL_SINGLE) begin
            last_idx = '0;
        end else begin
            last_idx = (ONE << policy_i) - ONE;
        end
        chunk_end_o = beat_i && (policy_i != POL_WHOLE) && (cur_idx == last_idx);

        state_d = state_q;
        if (accept_i && first_i) begin
            state_d.idx = '0;
        end
        if (accept_i && beat_i) begin
            if (split_i) begin
                state_d.idx = '0;
            end else if (cur_idx != '1) begin
                state_d.idx = cur_idx + ONE;
            end else begin
                state_d.idx = cur_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{idx: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assert_restart_after_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && beat_i && split_i) |=> (state_q.idx == '0));
    assert_hold_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i) |=> $stable(state_q.idx));
endmodule

// File: rtl/incr_burst_splitter.sv
module incr_burst_splitter
    import splitter_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            htrans_i,
    input  logic [2:0]            hburst_i,
    input  logic [2:0]            hsize_i,
    input  logic [BOUND_LOG2-1:0] haddr_lo_i,
    input  logic                  hready_i,
    input  logic                  slot_limit_i,
    input  logic                  cfg_wr_i,
    input  logic [POL_W-1:0]      cfg_wdata_i,
    input  logic                  cfg_wprot_i,
    output logic [POL_W-1:0]      cfg_rdata_o,
    output logic                  eob_o,
    output logic                  rearb_o
);
    policy_t policy_w;
    logic    is_first, is_seq, incr_beat;
    logic    cross_w, chunk_end_w, split_w;

    splitter_cfg_reg i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr_i),
        .wdata_i  (cfg_wdata_i),
        .wprot_i  (cfg_wprot_i),
        .policy_o (policy_w)
    );

    splitter_bound #(.BOUND_LOG2(BOUND_LOG2)) i_bound (
        .addr_i  (haddr_lo_i),
        .size_i  (hsize_i),
        .cross_o (cross_w)
    );

    always_comb begin
        is_first  = (htrans_i == TR_NONSEQ);
        is_seq    = (htrans_i == TR_SEQ);
        incr_beat = (is_first || is_seq) && (hburst_i == BURST_INCR);
        split_w   = incr_beat && (chunk_end_w || slot_limit_i || cross_w);
    end

    splitter_chunk_ctr #(.CW(CNT_W)) i_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .policy_i    (policy_w),
        .beat_i      (incr_beat),
        .first_i     (is_first),
        .accept_i    (hready_i),
        .split_i     (split_w),
        .chunk_end_o (chunk_end_w)
    );

    assign cfg_rdata_o = policy_w;
    assign eob_o       = split_w;
    assign rearb_o     = split_w && hready_i;

    assert_whole_only_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata_o == POL_WHOLE && !slot_limit_i && !cross_w) |-> !eob_o);
    assert_slot_forces_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_limit_i && (htrans_i[1]) && hburst_i == BURST_INCR) |-> eob_o);
    assert_single_every_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata_o == POL_SINGLE && htrans_i[1] && hburst_i == BURST_INCR) |-> eob_o);
    assert_untouched_transfers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!htrans_i[1] || hburst_i != BURST_INCR) |-> !eob_o);
    assert_boundary_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans_i[1] && hburst_i == BURST_INCR && hsize_i == 3'd2 && haddr_lo_i == 10'h3FC) |-> eob_o);
endmodule

// File: tb/test_incr_burst_splitter.sv
module test_incr_burst_splitter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] htrans = 2'b00;
    logic [2:0] hburst = 3'b001;
    logic [2:0] hsize = 3'd2;
    logic [9:0] haddr = '0;
    logic       hready = 1'b1;
    logic       slot = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] wdata = '0;
    logic       wprot = 1'b0;
    logic [2:0] rdata;
    logic       eob, rearb;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;

    always #10 clk = ~clk;

    incr_burst_splitter i_incr_burst_splitter (
        .clk(clk), .rst_n(rst_n), .htrans_i(htrans), .hburst_i(hburst),
        .hsize_i(hsize), .haddr_lo_i(haddr), .hready_i(hready),
        .slot_limit_i(slot), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
        .cfg_wprot_i(wprot), .cfg_rdata_o(rdata), .eob_o(eob), .rearb_o(rearb)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] t, input logic [9:0] a, input logic r, input logic s);
        @(negedge clk);
        htrans = t; haddr = a; hready = r; slot = s;
        #2;
    endtask

    task automatic beat(input logic [1:0] t, input logic [9:0] a, input logic r, input logic s,
                        input logic e_eob, input logic e_rearb, input string req);
        step(t, a, r, s);
        chk(int'(eob), int'(e_eob), req);
        chk(int'(rearb), int'(e_rearb), req);
    endtask

    task automatic go_idle();
        step(IDLE, '0, 1'b1, 1'b0);
        hburst = 3'b001; hsize = 3'd2;
    endtask

    task automatic set_policy(input logic [2:0] p);
        go_idle();
        @(negedge clk); wr = 1'b1; wdata = p;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic t_reset();
        #2;
        chk(int'(rdata), 0, "R1 reset code");
        chk(int'(eob), 0, "R1 reset eob");
    endtask

    task automatic t_whole();
        set_policy(3'd0);
        beat(NSEQ, 10'h100, 1'b1, 1'b0, 1'b0, 1'b0, "R2 first beat");
        for (int i = 1; i < 40; i++)
            beat(SEQ, 10'(10'h100 + i*4), 1'b1, 1'b0, 1'b0, 1'b0, "R2 unbroken");
    endtask

    task automatic t_boundary();
        set_policy(3'd0);
        beat(NSEQ, 10'h3F8, 1'b1, 1'b0, 1'b0, 1'b0, "R3 before edge");
        beat(SEQ, 10'h3FC, 1'b1, 1'b0, 1'b1, 1'b1, "R3 word edge");
        go_idle();
        hsize = 3'd1;
        beat(NSEQ, 10'h3FC, 1'b1, 1'b0, 1'b0, 1'b0, "R3 half before");
        beat(SEQ, 10'h3FE, 1'b1, 1'b0, 1'b1, 1'b1, "R3 half edge");
        set_policy(3'd3);
        hsize = 3'd3;
        beat(NSEQ, 10'h3F0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 dword before");
        beat(SEQ, 10'h3F8, 1'b1, 1'b0, 1'b1, 1'b1, "R3 dword edge mid-chunk");
    endtask

    task automatic t_slot();
        set_policy(3'd0);
        beat(NSEQ, 10'h000, 1'b1, 1'b0, 1'b0, 1'b0, "R4 start");
        for (int i = 1; i < 5; i++)
            beat(SEQ, 10'(i*4), 1'b1, 1'b0, 1'b0, 1'b0, "R4 before limit");
        beat(SEQ, 10'h014, 1'b1, 1'b1, 1'b1, 1'b1, "R4 limit under code 0");
        set_policy(3'd2);
        beat(NSEQ, 10'h000, 1'b1, 1'b0, 1'b0, 1'b0, "R4 chunk start");
        beat(SEQ, 10'h004, 1'b1, 1'b1, 1'b1, 1'b1, "R4 limit mid-chunk");
        for (int i = 0; i < 4; i++)
            beat(SEQ, 10'(8 + i*4), 1'b1, 1'b0, i == 3, i == 3, "R7 restart after limit");
    endtask

    task automatic t_single();
        set_policy(3'd1);
        beat(NSEQ, 10'h040, 1'b1, 1'b0, 1'b1, 1'b1, "R5 first beat");
        for (int i = 1; i < 5; i++)
            beat(SEQ, 10'(10'h040 + i*4), 1'b1, 1'b0, 1'b1, 1'b1, "R5 every beat");
    endtask

    task automatic t_chunks();
        for (int p = 2; p < 8; p++) begin
            int len;
            len = 1 << p;
            set_policy(3'(p));
            hsize = 3'd0;
            for (int i = 0; i < 2*len + 1; i++) begin
                logic e;
                e = ((i % len) == len - 1);
                beat(i == 0 ? NSEQ : SEQ, 10'(i), 1'b1, 1'b0, e, e, $sformatf("R6 code %0d beat %0d", p, i));
            end
        end
    endtask

    task automatic t_stalls();
        set_policy(3'd2);
        beat(NSEQ, 10'h000, 1'b1, 1'b0, 1'b0, 1'b0, "R7 idx0");
        beat(SEQ,  10'h004, 1'b0, 1'b0, 1'b0, 1'b0, "R7 wait idx1");
        beat(SEQ,  10'h004, 1'b1, 1'b0, 1'b0, 1'b0, "R7 idx1");
        beat(BUSY, 10'h008, 1'b1, 1'b0, 1'b0, 1'b0, "R7 busy");
        beat(SEQ,  10'h008, 1'b1, 1'b0, 1'b0, 1'b0, "R7 idx2");
        beat(SEQ,  10'h00C, 1'b0, 1'b0, 1'b1, 1'b0, "R10 flagged in wait");
        beat(SEQ,  10'h00C, 1'b1, 1'b0, 1'b1, 1'b1, "R10 flagged accepted");
        beat(SEQ,  10'h010, 1'b1, 1'b0, 1'b0, 1'b0, "R7 new chunk");
        beat(NSEQ, 10'h080, 1'b1, 1'b0, 1'b0, 1'b0, "R7 nonseq restart");
        beat(SEQ,  10'h084, 1'b1, 1'b0, 1'b0, 1'b0, "R7 idx1 after nonseq");
    endtask

    task automatic t_untouched();
        set_policy(3'd1);
        hburst = 3'b011;
        beat(NSEQ, 10'h000, 1'b1, 1'b0, 1'b0, 1'b0, "R8 fixed burst");
        for (int i = 1; i < 4; i++)
            beat(SEQ, 10'(i*4), 1'b1, 1'b1, 1'b0, 1'b0, "R8 fixed burst with limit");
        hburst = 3'b001;
        beat(IDLE, 10'h000, 1'b1, 1'b1, 1'b0, 1'b0, "R8 idle");
        beat(NSEQ, 10'h000, 1'b1, 1'b0, 1'b1, 1'b1, "R8 incr ref");
        beat(BUSY, 10'h004, 1'b1, 1'b1, 1'b0, 1'b0, "R8 busy");
    endtask

    task automatic t_protect();
        set_policy(3'd4);
        chk(int'(rdata), 4, "R9 open write");
        wprot = 1'b1;
        @(negedge clk); wr = 1'b1; wdata = 3'd6;
        @(negedge clk); wr = 1'b0;
        #2;
        chk(int'(rdata), 4, "R9 blocked write, readback while protected");
        wprot = 1'b0;
        set_policy(3'd6);
        chk(int'(rdata), 6, "R9 write after unprotect");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_whole();
        t_boundary();
        t_slot();
        t_single();
        t_chunks();
        t_stalls();
        t_untouched();
        t_protect();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule